// File: doc/BRIEF.md
# Timed Register-Write Sequencer on a Pass-Through Bus

The block sits in the path of a local register write bus and repeats every host write onto an output bus one clock later. It also holds a small program in a two-bank table, and on a trigger it plays that program back as its own register writes on the same output bus. Each program entry is four table words: a delay, a target address, and the low and high halves of the write data. The entry's write goes out first. The sequencer then waits the scaled delay before it fetches the next entry.

The host loads the table through the ordinary write bus. An external decoder asserts `tbl_we` for writes that fall in the table's address window. Table writes always go to the bank that is not running. When the host toggles `bank_sel`, the freshly loaded bank becomes active at the next idle point, and `active_bank` reports the bank in use. Host writes always win the output bus. A sequencer write that loses is dropped and flagged by a one-cycle `collision` pulse, which the surrounding logic may count or latch. Address bits above bit 15 of every sequencer write come from the `addr_pad` input.

Top module: `timed_write_sequencer`

## Requirements
- R1: A host write (`hin_we` high at a clock edge) appears on the output bus after that edge with `out_we` high and the same address and data, one cycle after it was presented. `out_we` is never high unless a host write or a sequencer write was due at the previous edge.
- R2: If a host write and a sequencer write are due at the same edge, the host write is the one put on the output bus and the sequencer write is lost.
- R3: `collision` is high for exactly the one cycle in which a lost sequencer write would have appeared. It is low at all other times.
- R4: Entry k uses table words 4k to 4k+3 of the active bank. Bits DELAY_W-1:0 of word 4k hold the delay D. Bits 15:0 of word 4k+1 hold the target. Bits 15:0 of words 4k+2 and 4k+3 hold the low and high data halves. The write has `out_data` = {high, low} and `out_addr` = {`addr_pad`, target}.
- R5: If `trig` is high at clock edge n while the sequencer is idle, the write of entry 0 is on the output bus in the cycle after edge n+5.
- R6: The write of entry k+1 appears 4 + D·2^GRAN cycles after the write of entry k, where D is the delay of entry k.
- R7: An entry whose target field (bits 15:0 of its second word) is zero ends the run without a write, regardless of that word's upper bits. The sequencer returns to entry 0 and stays idle until the next trigger, which replays the program from entry 0.
- R8: `trig` is sampled as a level. It is ignored while a run is in progress, so a trigger held high or repeated during a run starts no extra run.
- R9: A host write with `tbl_we` high stores `hin_data` at word `hin_addr[PC_W-1:0]` of the inactive bank. It is also passed through per R1, and it never alters the program that is running.
- R10: While idle, `active_bank` takes the value of `bank_sel` one cycle after the two differ. While a run is in progress, `active_bank` holds until the run ends. Each run uses the bank that is active when it starts.
- R11: After reset, `out_we` and `collision` are low, `active_bank` is 0, and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Run trigger, level sampled |
| hin_we | input | 1 | Host write strobe |
| hin_addr | input | ADDR_W | Host write address |
| hin_data | input | 32 | Host write data |
| tbl_we | input | 1 | Decoded enable: current host write targets the program table |
| addr_pad | input | ADDR_W-16 | Upper address bits for sequencer writes |
| bank_sel | input | 1 | Requested active table bank |
| active_bank | output | 1 | Table bank in use |
| out_we | output | 1 | Output write strobe |
| out_addr | output | ADDR_W | Output write address |
| out_data | output | 32 | Output write data |
| collision | output | 1 | One-cycle pulse for a dropped sequencer write |

## Verification
A pass-through write is due one cycle after it is driven. A bank change while idle is also due one cycle later. The first program write is due in the cycle after the fifth edge following the trigger edge, and each later write follows after 4 + D·2^GRAN more cycles. The bench drives inputs and samples outputs on falling edges, and stamps every output write with a count of rising edges. It then compares those stamps against arrival times it computes from the delays it loaded. A collision is provoked by placing a host write exactly on the predicted edge of a sequencer write.

// File: rtl/tws_pkg.sv
package tws_pkg;
   localparam int WORD_W = 32;
   localparam int HALF_W = 16;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [HALF_W-1:0] half_t;

   // Position of a word inside a four-word program entry.
   typedef enum logic [1:0] {
      SLOT_DELAY = 2'd0,
      SLOT_TGT   = 2'd1,
      SLOT_LO    = 2'd2,
      SLOT_HI    = 2'd3
   } slot_e;
endpackage

// File: rtl/tws_prog_ram.sv
module tws_prog_ram
   import tws_pkg::*;
#(
   parameter int PC_W = 6
) (
   input  logic            clk,
   input  logic            wr_en,
   input  logic            wr_bank,
   input  logic [PC_W-1:0] wr_idx,
   input  word_t           wr_data,
   input  logic            rd_bank,
   input  logic [PC_W-1:0] rd_idx,
   output word_t           rd_data
);
   localparam int DEPTH = 2 ** (PC_W + 1);

   word_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[{wr_bank, wr_idx}] <= wr_data;
   end

   always_ff @(posedge clk) begin
      rd_data <= mem[{rd_bank, rd_idx}];
   end
endmodule

// File: rtl/tws_engine.sv
module tws_engine
   import tws_pkg::*;
#(
   parameter int PC_W    = 6,
   parameter int DELAY_W = 16,
   parameter int GRAN    = 0,
   parameter int ADDR_W  = 17
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig,
   input  logic              bank_sel,
   input  logic [ADDR_W-17:0] pad,
   input  word_t             rd_data,
   output logic [PC_W-1:0]   rd_idx,
   output logic              bank,
   output logic              running,
   output logic              req,
   output logic [ADDR_W-1:0] req_addr,
   output word_t             req_data
);
   localparam int CNT_W = DELAY_W + GRAN;

   logic               run_q;
   logic               rv_q;
   slot_e              slot_q;
   logic [PC_W-1:0]    pc_q;
   logic [CNT_W-1:0]   wait_q;
   logic [DELAY_W-1:0] dly_q;
   half_t              tgt_q;
   half_t              lo_q;
   logic               bank_q;
   logic [CNT_W-1:0]   dly_ticks;
   logic               adv;
   logic               fin;
   logic               issue;
   logic               unused_rd_hi;

   // Delay unit selection: plain cycles or cycles scaled by 2^GRAN.
   generate
      if (GRAN == 0) begin : g_unit_tick
         assign dly_ticks = dly_q;
      end else begin : g_scaled_tick
         assign dly_ticks = {dly_q, {GRAN{1'b0}}};
      end
   endgenerate

   assign adv   = run_q && (wait_q == '0);
   assign fin   = rv_q && (slot_q == SLOT_TGT) && (rd_data[HALF_W-1:0] == '0);
   assign issue = rv_q && (slot_q == SLOT_HI);
   assign unused_rd_hi = ^rd_data[WORD_W-1:HALF_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         rv_q   <= 1'b0;
         slot_q <= SLOT_DELAY;
         pc_q   <= '0;
         wait_q <= '0;
         dly_q  <= '0;
         tgt_q  <= '0;
         lo_q   <= '0;
         bank_q <= 1'b0;
      end else begin
         if (!run_q) begin
            if (bank_sel != bank_q)
               bank_q <= bank_sel;
            if (trig)
               run_q <= 1'b1;
         end
         rv_q   <= adv;
         slot_q <= slot_e'(pc_q[1:0]);
         if (adv)
            pc_q <= pc_q + 1'b1;
         if (wait_q != '0)
            wait_q <= wait_q - 1'b1;
         if (rv_q) begin
            case (slot_q)
               SLOT_DELAY: dly_q  <= rd_data[DELAY_W-1:0];
               SLOT_TGT:   tgt_q  <= rd_data[HALF_W-1:0];
               SLOT_LO:    lo_q   <= rd_data[HALF_W-1:0];
               SLOT_HI:    wait_q <= dly_ticks;
               default:    ;
            endcase
         end
         if (fin) begin
            run_q <= 1'b0;
            rv_q  <= 1'b0;
            pc_q  <= '0;
         end
      end
   end

   assign rd_idx   = pc_q;
   assign bank     = bank_q;
   assign running  = run_q;
   assign req      = issue;
   assign req_addr = {pad, tgt_q};
   assign req_data = {rd_data[HALF_W-1:0], lo_q};
endmodule

// File: rtl/tws_merge.sv
module tws_merge
   import tws_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  word_t             host_data,
   input  logic              seq_we,
   input  logic [ADDR_W-1:0] seq_addr,
   input  word_t             seq_data,
   output logic              out_we,
   output logic [ADDR_W-1:0] out_addr,
   output word_t             out_data,
   output logic              lost
);
   always_ff @(posedge clk) begin
      if (rst) begin
         out_we <= 1'b0;
         lost   <= 1'b0;
      end else begin
         out_we <= host_we | seq_we;
         lost   <= host_we & seq_we;
      end
   end

   // Host side always wins the shared output register.
   always_ff @(posedge clk) begin
      if (host_we) begin
         out_addr <= host_addr;
         out_data <= host_data;
      end else if (seq_we) begin
         out_addr <= seq_addr;
         out_data <= seq_data;
      end
   end
endmodule

// File: rtl/timed_write_sequencer.sv
module timed_write_sequencer
   import tws_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int PC_W    = 6,
   parameter int DELAY_W = 16,
   parameter int GRAN    = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig,
   input  logic              hin_we,
   input  logic [ADDR_W-1:0] hin_addr,
   input  logic [31:0]       hin_data,
   input  logic              tbl_we,
   input  logic [ADDR_W-17:0] addr_pad,
   input  logic              bank_sel,
   output logic              active_bank,
   output logic              out_we,
   output logic [ADDR_W-1:0] out_addr,
   output logic [31:0]       out_data,
   output logic              collision
);
   generate
      if (ADDR_W < 17) begin : g_bad_addr_w
         $error("ADDR_W must be at least 17");
      end
      if (PC_W < 2 || PC_W > 10) begin : g_bad_pc_w
         $error("PC_W must lie in 2..10");
      end
      if (DELAY_W < 1 || DELAY_W > 16) begin : g_bad_delay_w
         $error("DELAY_W must lie in 1..16");
      end
      if (GRAN < 0 || GRAN > 16) begin : g_bad_gran
         $error("GRAN must lie in 0..16");
      end
   endgenerate

   word_t             rd_data;
   logic [PC_W-1:0]   rd_idx;
   logic              seq_run;
   logic              seq_req;
   logic [ADDR_W-1:0] seq_addr;
   word_t             seq_data;

   tws_prog_ram #(.PC_W(PC_W)) u_ram (
      .clk     (clk),
      .wr_en   (hin_we & tbl_we),
      .wr_bank (~active_bank),
      .wr_idx  (hin_addr[PC_W-1:0]),
      .wr_data (hin_data),
      .rd_bank (active_bank),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   tws_engine #(
      .PC_W    (PC_W),
      .DELAY_W (DELAY_W),
      .GRAN    (GRAN),
      .ADDR_W  (ADDR_W)
   ) u_eng (
      .clk      (clk),
      .rst      (rst),
      .trig     (trig),
      .bank_sel (bank_sel),
      .pad      (addr_pad),
      .rd_data  (rd_data),
      .rd_idx   (rd_idx),
      .bank     (active_bank),
      .running  (seq_run),
      .req      (seq_req),
      .req_addr (seq_addr),
      .req_data (seq_data)
   );

   tws_merge #(.ADDR_W(ADDR_W)) u_merge (
      .clk       (clk),
      .rst       (rst),
      .host_we   (hin_we),
      .host_addr (hin_addr),
      .host_data (hin_data),
      .seq_we    (seq_req),
      .seq_addr  (seq_addr),
      .seq_data  (seq_data),
      .out_we    (out_we),
      .out_addr  (out_addr),
      .out_data  (out_data),
      .lost      (collision)
   );
endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst,
   input logic              trig,
   input logic              hin_we,
   input logic [ADDR_W-1:0] hin_addr,
   input logic [31:0]       hin_data,
   input logic              bank_sel,
   input logic              active_bank,
   input logic              out_we,
   input logic [ADDR_W-1:0] out_addr,
   input logic [31:0]       out_data,
   input logic              collision,
   input logic              seq_run,
   input logic              seq_req
);
   // R1
   pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
      hin_we |=> out_we && out_addr == $past(hin_addr) && out_data == $past(hin_data));

   // R1
   no_spurious_write_chk: assert property (@(posedge clk) disable iff (rst)
      out_we |-> $past(hin_we) || $past(seq_req));

   // R2
   collision_cause_chk: assert property (@(posedge clk) disable iff (rst)
      collision |-> $past(hin_we) && $past(seq_req));

   // R3
   collision_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      collision |=> !collision);

   // R8
   trig_start_chk: assert property (@(posedge clk) disable iff (rst)
      (trig && !seq_run) |=> seq_run);

   // R10
   bank_idle_swap_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(active_bank) |-> !$past(seq_run) && active_bank == $past(bank_sel));

   // R4
   req_in_run_chk: assert property (@(posedge clk) disable iff (rst)
      seq_req |-> seq_run);
endmodule

bind timed_write_sequencer tws_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/timed_write_sequencer_test.sv
module timed_write_sequencer_test;
   localparam int ADDR_W  = 18;
   localparam int PC_W    = 5;
   localparam int DELAY_W = 8;
   localparam int GRAN    = 1;
   localparam logic [1:0] PAD = 2'b10;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              trig = 1'b0;
   logic              hin_we = 1'b0;
   logic [ADDR_W-1:0] hin_addr = '0;
   logic [31:0]       hin_data = '0;
   logic              tbl_we = 1'b0;
   logic              bank_sel = 1'b0;
   logic              active_bank;
   logic              out_we;
   logic [ADDR_W-1:0] out_addr;
   logic [31:0]       out_data;
   logic              collision;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   logic [ADDR_W-1:0] log_a [64];
   logic [31:0]       log_d [64];
   int                log_t [64];
   int                log_n = 0;

   timed_write_sequencer #(
      .ADDR_W(ADDR_W), .PC_W(PC_W), .DELAY_W(DELAY_W), .GRAN(GRAN)
   ) uut (
      .clk(clk), .rst(rst), .trig(trig), .hin_we(hin_we), .hin_addr(hin_addr),
      .hin_data(hin_data), .tbl_we(tbl_we), .addr_pad(PAD), .bank_sel(bank_sel),
      .active_bank(active_bank), .out_we(out_we), .out_addr(out_addr),
      .out_data(out_data), .collision(collision)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 20000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<=20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // Log sequencer-range writes (address bits 15:8 neither 00 nor FF).
   always @(negedge clk) begin
      if (!rst && out_we && out_addr[15:8] != 8'h00 && out_addr[15:8] != 8'hFF && log_n < 64) begin
         log_a[log_n] = out_addr;
         log_d[log_n] = out_data;
         log_t[log_n] = cyc;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Program 0 (A): 4 entries; program 1 (B): 3 entries.
   function automatic int ent_cnt(input int p);
      return (p == 0) ? 4 : 3;
   endfunction
   function automatic int dly(input int p, input int i);
      int da [4] = '{0, 10, 1, 3};
      int db [4] = '{2, 0, 5, 0};
      return (p == 0) ? da[i] : db[i];
   endfunction
   function automatic logic [15:0] tgt(input int p, input int i);
      return (p == 0) ? 16'h4100 + 16'(i) * 16'h0104 : 16'h7000 + 16'(i) * 16'h0021;
   endfunction
   function automatic logic [15:0] lo_h(input int p, input int i);
      return (p == 0) ? 16'hA000 + 16'(i) : 16'hC0DE ^ 16'(i * 7);
   endfunction
   function automatic logic [15:0] hi_h(input int p, input int i);
      return (p == 0) ? 16'h5A00 + 16'(i * 3) : 16'h1230 + 16'(i);
   endfunction
   // R4: word layout; upper halves carry junk that must be ignored.
   function automatic logic [31:0] word(input int p, input int k);
      int i = k / 4;
      int s = k % 4;
      if (i >= ent_cnt(p)) begin
         // R7: terminator with zero target field but nonzero upper bits
         return (s == 1) ? 32'hFFFF_0000 : 32'h0;
      end
      case (s)
         0: return {24'hEE0000, 8'(dly(p, i))};
         1: return {16'hBEEF, tgt(p, i)};
         2: return {16'h7777, lo_h(p, i)};
         default: return {16'h3333, hi_h(p, i)};
      endcase
   endfunction

   task automatic load_prog(input int p);
      int nw = 4 * (ent_cnt(p) + 1);
      for (int k = 0; k < nw; k++) begin
         hin_we = 1'b1; tbl_we = 1'b1;
         hin_addr = ADDR_W'(k); hin_data = word(p, k);
         @(negedge clk);
         // R9: table writes also pass through
         chk(out_we && out_data == word(p, k) && out_addr == ADDR_W'(k), "R9",
             "table write pass-through", {31'd0, out_we, out_data}, {32'd1, word(p, k)});
      end
      hin_we = 1'b0; tbl_we = 1'b0;
   endtask

   task automatic expect_run(input int c0, input int p, input int skip);
      int e = c0 + 6;
      int n = 0;
      for (int i = 0; i < ent_cnt(p); i++) begin
         if (i != skip) begin
            // R5 / R6 arrival time
            chk(log_t[n] == e, (i == 0) ? "R5" : "R6", "write time", 64'(log_t[n]), 64'(e));
            // R4 address and data composition
            chk(log_a[n] == {PAD, tgt(p, i)}, "R4", "write address",
                64'(log_a[n]), 64'({PAD, tgt(p, i)}));
            chk(log_d[n] == {hi_h(p, i), lo_h(p, i)}, "R4", "write data",
                64'(log_d[n]), 64'({hi_h(p, i), lo_h(p, i)}));
            n++;
         end
         e += 4 + (dly(p, i) << GRAN);
      end
      // R7 / R8: terminator ends run, no extra writes or restarts
      chk(log_n == n, "R7", "write count per run", 64'(log_n), 64'(n));
   endtask

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 reset state
      chk(out_we == 1'b0, "R11", "out_we after reset", 64'(out_we), 64'd0);
      chk(collision == 1'b0, "R11", "collision after reset", 64'(collision), 64'd0);
      chk(active_bank == 1'b0, "R11", "bank after reset", 64'(active_bank), 64'd0);

      // R1 pass-through sweep, back to back
      for (int i = 0; i < 8; i++) begin
         logic [ADDR_W-1:0] a = ADDR_W'(i * 32'h9A5 + 32'h10);
         logic [31:0] d = (32'h1 << (i * 4)) | 32'(i * 32'h0101_0000);
         hin_we = 1'b1; hin_addr = a; hin_data = d;
         @(negedge clk);
         chk(out_we && out_addr == a && out_data == d, "R1", "pass-through",
             {out_we, 13'd0, 18'(out_addr), out_data}, {1'b1, 13'd0, 18'(a), d});
      end
      hin_we = 1'b0;
      @(negedge clk);
      chk(out_we == 1'b0, "R1", "idle bus after writes", 64'(out_we), 64'd0);

      // Load A into inactive bank 1, swap while idle
      load_prog(0);
      bank_sel = 1'b1;
      @(negedge clk);
      chk(active_bank == 1'b1, "R10", "idle swap one cycle later", 64'(active_bank), 64'd1);

      // Run A; load B mid-run, request swap and retrigger mid-run
      log_n = 0;
      c0 = cyc;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      while (cyc < c0 + 11) @(negedge clk);
      load_prog(1);
      bank_sel = 1'b0;
      @(negedge clk);
      chk(active_bank == 1'b1, "R10", "bank held while running", 64'(active_bank), 64'd1);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      while (cyc < c0 + 150) @(negedge clk);
      expect_run(c0, 0, -1);
      chk(active_bank == 1'b0, "R10", "swap after run end", 64'(active_bank), 64'd0);

      // Run B, trig held high 3 cycles, with a collision on entry 0
      log_n = 0;
      c0 = cyc;
      trig = 1'b1;
      repeat (3) @(negedge clk);
      trig = 1'b0;
      while (cyc < c0 + 5) @(negedge clk);
      hin_we = 1'b1; hin_addr = {2'b11, 16'hFF55}; hin_data = 32'hDEAD_0001;
      @(negedge clk);
      hin_we = 1'b0;
      chk(out_we && out_addr == {2'b11, 16'hFF55} && out_data == 32'hDEAD_0001, "R2",
          "host wins on clash", {14'd0, out_addr, out_data}, {14'd0, 2'b11, 16'hFF55, 32'hDEAD_0001});
      chk(collision == 1'b1, "R3", "collision pulse", 64'(collision), 64'd1);
      @(negedge clk);
      chk(collision == 1'b0, "R3", "collision one cycle", 64'(collision), 64'd0);
      while (cyc < c0 + 120) @(negedge clk);
      expect_run(c0, 1, 0);

      // Replay B from entry 0 after termination
      log_n = 0;
      c0 = cyc;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      while (cyc < c0 + 120) @(negedge clk);
      expect_run(c0, 1, -1);
      chk(collision == 1'b0, "R3", "no collision without clash", 64'(collision), 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule